// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This unit sits beside the core's execute stage and performs processor state entry when an event must be serviced. On a one-cycle `take_i` strobe it looks at one pending exception code and one hardware interrupt request, decides which of them, if either, is serviced, and in the same clock edge writes the shadow copies of the status word, program counter and stack register, the new status word, the handler address and the event code register.

A blocked exception is turned into a reset request instead of an entry. Interrupts are held off while the core is blocked and awake, or while the faulting instruction sits in a branch delay slot. An interrupt is also held off when the external priority controller has no vector for the current mask level. On each accepted entry the core clears its sleep and delay-slot flags in response to `entry_done_o`.

Status word bits used by the block: MD is bit 30, RB is bit 29, BL is bit 28, FD is bit 15, and the interrupt mask is bits 7:4.

Top module: `exc_entry_seq`

## Requirements
- R1: When `take_i` is high and both `exc_valid_i` and `irq_req_i` are high, the exception is serviced. `expevt_o` takes the code and `intevt_o` keeps its value.
- R2: When BL (SR bit 28) is set and an exception with a code other than 0x1E0 is taken, `reset_req_o` is high for the cycle after the strobe. `entry_done_o` stays low and every state output keeps its value. A code of 0x1E0 with BL set enters normally.
- R3: When BL is set, an interrupt is ignored unless `sleep_i` is high. When BL is clear, `sleep_i` has no effect.
- R4: `irq_mask_o` equals SR bits 7:4. An interrupt with `irq_vec_valid_i` low is ignored and all outputs keep their values.
- R5: On an entry, `ssr_o` takes SR, `sgr_o` takes R15 and `spc_o` takes PC. `sr_o` equals SR with bits 30, 29 and 28 set.
- R6: With `dslot_i` high, an exception entry saves PC minus 2 into `spc_o`. An interrupt is not accepted while `dslot_i` is high.
- R7: Exception codes 0x000, 0x020 and 0x140 clear SR bit 15, set SR bits 7:4 to 0xF and jump to 0xA0000000.
- R8: Exception codes 0x040 and 0x060 jump to VBR+0x400. Every other non-reset-class exception jumps to VBR+0x100.
- R9: For code 0x160, the saved PC is the PC plus 2. This adjustment is added after any delay-slot adjustment.
- R10: An accepted interrupt writes its vector into `intevt_o` and jumps to VBR+0x600, and `expevt_o` keeps its value.
- R11: All outputs are zero after reset. Outputs change only at an edge where `take_i` is high. `entry_done_o` is high for the one cycle after a strobe that produced an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| take_i | input | 1 | One-cycle strobe: evaluate and perform entry |
| exc_valid_i | input | 1 | An exception is pending |
| exc_code_i | input | CODE_W | Pending exception code |
| irq_req_i | input | 1 | Hardware interrupt request |
| irq_vec_valid_i | input | 1 | Controller has a vector for the current mask level |
| irq_vec_i | input | CODE_W | Interrupt vector from the controller |
| irq_mask_o | output | 4 | Current mask level sent to the controller |
| sr_i | input | XLEN | Current status word |
| pc_i | input | XLEN | Current program counter |
| r15_i | input | XLEN | Current stack register |
| vbr_i | input | XLEN | Vector base |
| dslot_i | input | 1 | Faulting instruction is in a delay slot |
| sleep_i | input | 1 | Core is in sleep state |
| ssr_o | output | XLEN | Saved status word |
| spc_o | output | XLEN | Saved return address |
| sgr_o | output | XLEN | Saved stack register |
| sr_o | output | XLEN | New status word |
| pc_o | output | XLEN | Handler address |
| expevt_o | output | CODE_W | Last exception code entered |
| intevt_o | output | CODE_W | Last interrupt vector entered |
| entry_done_o | output | 1 | Entry performed on the previous edge |
| reset_req_o | output | 1 | Blocked exception escalated to reset |

## Verification
The assertions assume that the input fields are stable across the sampling edge. They also assume that the code, vector and state inputs are meaningful only on cycles where `take_i` is high. Nothing constrains the combinations of those inputs: BL, sleep, delay slot, vector valid and both request lines may all be high at once. The stimulus therefore drives every input only after the edge and mixes all of them freely. Reset-class, miss-class, trap and 0x1E0 codes are chosen more often than other codes, so that each vector path and each escalation path is hit many times.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [1:0] {
    KIND_NONE,
    KIND_RESET_REQ,
    KIND_EXC,
    KIND_IRQ
  } entry_kind_e;

  localparam int SR_MD_BIT = 30;
  localparam int SR_RB_BIT = 29;
  localparam int SR_BL_BIT = 28;
  localparam int SR_FD_BIT = 15;
  localparam int SR_IM_LSB = 4;
  localparam int IM_W      = 4;

  localparam int N_RST_CODES = 3;
  localparam int RST_CODES [N_RST_CODES] = '{'h000, 'h020, 'h140};
  localparam int N_TLB_CODES = 2;
  localparam int TLB_CODES [N_TLB_CODES] = '{'h040, 'h060};

  localparam int CODE_UNBLOCKED = 'h1E0;
  localparam int CODE_TRAP      = 'h160;

  localparam int OFS_GENERAL = 'h100;
  localparam int OFS_TLB     = 'h400;
  localparam int OFS_IRQ     = 'h600;
  localparam logic [63:0] RESET_TARGET = 64'h0000_0000_A000_0000;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              exc_valid_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              irq_req_i,
  input  logic              irq_vec_valid_i,
  input  logic              bl_i,
  input  logic              sleep_i,
  input  logic              dslot_i,
  output entry_kind_e       kind_o
);
  logic unblocked_code;
  logic irq_ok;

  assign unblocked_code = (exc_code_i == CODE_W'(CODE_UNBLOCKED));
  // delay slots are indivisible; blocked core only wakes from sleep
  assign irq_ok = irq_req_i && !dslot_i && (!bl_i || sleep_i) && irq_vec_valid_i;

  always_comb begin
    kind_o = KIND_NONE;
    if (take_i) begin
      if (exc_valid_i) begin
        kind_o = (bl_i && !unblocked_code) ? KIND_RESET_REQ : KIND_EXC;
      end else if (irq_ok) begin
        kind_o = KIND_IRQ;
      end
    end
  end

  assert_exc_over_irq_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && exc_valid_i && irq_req_i && !bl_i) |-> (kind_o == KIND_EXC));

  assert_blocked_exc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && exc_valid_i && bl_i && exc_code_i != CODE_W'(CODE_UNBLOCKED))
      |-> (kind_o == KIND_RESET_REQ));

  assert_bl_irq_masked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !exc_valid_i && bl_i && !sleep_i) |-> (kind_o == KIND_NONE));

  assert_no_vector_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !exc_valid_i && !irq_vec_valid_i) |-> (kind_o == KIND_NONE));

  assert_dslot_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !exc_valid_i && dslot_i) |-> (kind_o == KIND_NONE));
endmodule

// File: rtl/exc_target_gen.sv
module exc_target_gen
  import exc_entry_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int CODE_W     = 12,
  parameter int INSN_BYTES = 2
) (
  input  entry_kind_e       kind_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   vbr_i,
  input  logic              dslot_i,
  output logic [XLEN-1:0]   new_sr_o,
  output logic [XLEN-1:0]   new_pc_o,
  output logic [XLEN-1:0]   ret_pc_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [N_RST_CODES-1:0] rst_hit;
  logic [N_TLB_CODES-1:0] tlb_hit;
  logic is_exc, reset_class, tlb_class, trap_code;
  logic [XLEN-1:0] rewound;

  for (genvar g = 0; g < N_RST_CODES; g++) begin : g_rst_cmp
    assign rst_hit[g] = (exc_code_i == CODE_W'(RST_CODES[g]));
  end
  for (genvar g = 0; g < N_TLB_CODES; g++) begin : g_tlb_cmp
    assign tlb_hit[g] = (exc_code_i == CODE_W'(TLB_CODES[g]));
  end

  assign is_exc      = (kind_i == KIND_EXC);
  assign reset_class = is_exc && (|rst_hit);
  assign tlb_class   = |tlb_hit;
  assign trap_code   = (exc_code_i == CODE_W'(CODE_TRAP));

  // delay-slot rewind first, trap advance on top of it
  assign rewound  = dslot_i ? (pc_i - STEP) : pc_i;
  assign ret_pc_o = (is_exc && trap_code) ? (rewound + STEP) : rewound;

  always_comb begin
    new_sr_o = sr_i;
    new_sr_o[SR_MD_BIT] = 1'b1;
    new_sr_o[SR_RB_BIT] = 1'b1;
    new_sr_o[SR_BL_BIT] = 1'b1;
    if (reset_class) begin
      new_sr_o[SR_FD_BIT] = 1'b0;
      new_sr_o[SR_IM_LSB +: IM_W] = '1;
    end
  end

  always_comb begin
    if (!is_exc)          new_pc_o = vbr_i + XLEN'(OFS_IRQ);
    else if (reset_class) new_pc_o = XLEN'(RESET_TARGET);
    else if (tlb_class)   new_pc_o = vbr_i + XLEN'(OFS_TLB);
    else                  new_pc_o = vbr_i + XLEN'(OFS_GENERAL);
  end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  entry_kind_e       kind_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [XLEN-1:0]   r15_i,
  input  logic [XLEN-1:0]   new_sr_i,
  input  logic [XLEN-1:0]   new_pc_i,
  input  logic [XLEN-1:0]   ret_pc_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic [CODE_W-1:0] irq_vec_i,
  output logic [XLEN-1:0]   ssr_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   sgr_o,
  output logic [XLEN-1:0]   sr_o,
  output logic [XLEN-1:0]   pc_o,
  output logic [CODE_W-1:0] expevt_o,
  output logic [CODE_W-1:0] intevt_o,
  output logic              entry_done_o,
  output logic              reset_req_o
);
  logic enter;
  assign enter = (kind_i == KIND_EXC) || (kind_i == KIND_IRQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ssr_o        <= '0;
      spc_o        <= '0;
      sgr_o        <= '0;
      sr_o         <= '0;
      pc_o         <= '0;
      expevt_o     <= '0;
      intevt_o     <= '0;
      entry_done_o <= 1'b0;
      reset_req_o  <= 1'b0;
    end else begin
      entry_done_o <= enter;
      reset_req_o  <= (kind_i == KIND_RESET_REQ);
      if (enter) begin
        ssr_o <= sr_i;
        spc_o <= ret_pc_i;
        sgr_o <= r15_i;
        sr_o  <= new_sr_i;
        pc_o  <= new_pc_i;
      end
      if (kind_i == KIND_EXC) expevt_o <= exc_code_i;
      if (kind_i == KIND_IRQ) intevt_o <= irq_vec_i;
    end
  end

  assert_done_xor_reset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(entry_done_o && reset_req_o));

  assert_mode_bits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_done_o |-> (sr_o[SR_MD_BIT] && sr_o[SR_RB_BIT] && sr_o[SR_BL_BIT]));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int CODE_W     = 12,
  parameter int INSN_BYTES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              exc_valid_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              irq_req_i,
  input  logic              irq_vec_valid_i,
  input  logic [CODE_W-1:0] irq_vec_i,
  output logic [3:0]        irq_mask_o,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   r15_i,
  input  logic [XLEN-1:0]   vbr_i,
  input  logic              dslot_i,
  input  logic              sleep_i,
  output logic [XLEN-1:0]   ssr_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   sgr_o,
  output logic [XLEN-1:0]   sr_o,
  output logic [XLEN-1:0]   pc_o,
  output logic [CODE_W-1:0] expevt_o,
  output logic [CODE_W-1:0] intevt_o,
  output logic              entry_done_o,
  output logic              reset_req_o
);
  entry_kind_e     kind;
  logic [XLEN-1:0] new_sr, new_pc, ret_pc;

  assign irq_mask_o = sr_i[SR_IM_LSB +: IM_W];

  exc_arbiter #(.CODE_W(CODE_W)) i_arbiter (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .take_i          (take_i),
    .exc_valid_i     (exc_valid_i),
    .exc_code_i      (exc_code_i),
    .irq_req_i       (irq_req_i),
    .irq_vec_valid_i (irq_vec_valid_i),
    .bl_i            (sr_i[SR_BL_BIT]),
    .sleep_i         (sleep_i),
    .dslot_i         (dslot_i),
    .kind_o          (kind)
  );

  exc_target_gen #(.XLEN(XLEN), .CODE_W(CODE_W), .INSN_BYTES(INSN_BYTES)) i_target (
    .kind_i     (kind),
    .exc_code_i (exc_code_i),
    .sr_i       (sr_i),
    .pc_i       (pc_i),
    .vbr_i      (vbr_i),
    .dslot_i    (dslot_i),
    .new_sr_o   (new_sr),
    .new_pc_o   (new_pc),
    .ret_pc_o   (ret_pc)
  );

  exc_state_regs #(.XLEN(XLEN), .CODE_W(CODE_W)) i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .kind_i       (kind),
    .sr_i         (sr_i),
    .r15_i        (r15_i),
    .new_sr_i     (new_sr),
    .new_pc_i     (new_pc),
    .ret_pc_i     (ret_pc),
    .exc_code_i   (exc_code_i),
    .irq_vec_i    (irq_vec_i),
    .ssr_o        (ssr_o),
    .spc_o        (spc_o),
    .sgr_o        (sgr_o),
    .sr_o         (sr_o),
    .pc_o         (pc_o),
    .expevt_o     (expevt_o),
    .intevt_o     (intevt_o),
    .entry_done_o (entry_done_o),
    .reset_req_o  (reset_req_o)
  );

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> ($stable(pc_o) && $stable(ssr_o) && $stable(expevt_o) &&
                 $stable(intevt_o) && !entry_done_o && !reset_req_o));

  assert_reset_req_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == KIND_RESET_REQ) |=> (reset_req_o && $stable(pc_o) && $stable(sr_o) &&
                                  $stable(expevt_o)));

  assert_save_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == KIND_EXC || kind == KIND_IRQ) |=>
      (ssr_o == $past(sr_i) && sgr_o == $past(r15_i) && entry_done_o));

  assert_irq_target_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == KIND_IRQ) |=> (pc_o == $past(vbr_i) + XLEN'(OFS_IRQ) &&
                            intevt_o == $past(irq_vec_i) && $stable(expevt_o)));

  assert_exc_code_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == KIND_EXC) |=> (expevt_o == $past(exc_code_i) && $stable(intevt_o)));
endmodule

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        take = 1'b0, exc_v = 1'b0, irq = 1'b0, vv = 1'b0, ds = 1'b0, sl = 1'b0;
  logic [11:0] code = '0, vec = '0;
  logic [31:0] sr = '0, pc = '0, r15 = '0, vbr = '0;
  logic [3:0]  mask;
  logic [31:0] ssr, spc, sgr, nsr, npc;
  logic [11:0] expevt, intevt;
  logic        done, rreq;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  exc_entry_seq i_exc_entry_seq (
    .clk_i(clk), .rst_ni(rst_n), .take_i(take), .exc_valid_i(exc_v), .exc_code_i(code),
    .irq_req_i(irq), .irq_vec_valid_i(vv), .irq_vec_i(vec), .irq_mask_o(mask),
    .sr_i(sr), .pc_i(pc), .r15_i(r15), .vbr_i(vbr), .dslot_i(ds), .sleep_i(sl),
    .ssr_o(ssr), .spc_o(spc), .sgr_o(sgr), .sr_o(nsr), .pc_o(npc),
    .expevt_o(expevt), .intevt_o(intevt), .entry_done_o(done), .reset_req_o(rreq)
  );

  // reference model
  logic [31:0] m_ssr, m_spc, m_sgr, m_sr, m_pc, ret, ns;
  logic [11:0] m_expevt, m_intevt;
  logic        m_done, m_rreq, bl;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ssr = 0; m_spc = 0; m_sgr = 0; m_sr = 0; m_pc = 0;
      m_expevt = 0; m_intevt = 0; m_done = 0; m_rreq = 0;
    end else begin
      m_done = 0; m_rreq = 0;
      if (take) begin
        bl = sr[28];
        if (exc_v && bl && code != 12'h1E0) m_rreq = 1;
        else if (exc_v || (irq && !ds && (!bl || sl) && vv)) begin
          m_done = 1;
          m_ssr = sr; m_sgr = r15;
          ret = pc;
          if (ds) ret = ret - 2;
          if (exc_v && code == 12'h160) ret = ret + 2;
          m_spc = ret;
          ns = sr | 32'h7000_0000;
          if (exc_v) begin
            m_expevt = code;
            if (code == 12'h000 || code == 12'h020 || code == 12'h140) begin
              ns[15] = 1'b0; ns[7:4] = 4'hF; m_pc = 32'hA000_0000;
            end else if (code == 12'h040 || code == 12'h060) m_pc = vbr + 32'h400;
            else m_pc = vbr + 32'h100;
          end else begin
            m_intevt = vec;
            m_pc = vbr + 32'h600;
          end
          m_sr = ns;
        end
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R11 R2 R3 R4 R6 entry_done", 32'(done), 32'(m_done));
      check("R2 reset_req", 32'(rreq), 32'(m_rreq));
      check("R5 ssr", ssr, m_ssr);
      check("R5 sgr", sgr, m_sgr);
      check("R5 R6 R9 spc", spc, m_spc);
      check("R5 R7 sr", nsr, m_sr);
      check("R7 R8 R10 pc", npc, m_pc);
      check("R1 R10 expevt", 32'(expevt), 32'(m_expevt));
      check("R1 R10 intevt", 32'(intevt), 32'(m_intevt));
    end
  end

  task automatic drive(input logic t, input logic ev, input logic [11:0] c, input logic iq,
                       input logic v, input logic [11:0] vc, input logic [31:0] s,
                       input logic [31:0] p, input logic [31:0] r, input logic [31:0] b,
                       input logic d, input logic slp);
    @(posedge clk);
    #2;
    take = t; exc_v = ev; code = c; irq = iq; vv = v; vec = vc;
    sr = s; pc = p; r15 = r; vbr = b; ds = d; sl = slp;
    #1;
    check("R4 irq_mask", 32'(mask), 32'(s[7:4]));
  endtask

  function automatic logic [11:0] pick_code();
    case ($urandom_range(0, 9))
      0: return 12'h000;
      1: return 12'h020;
      2: return 12'h140;
      3: return 12'h040;
      4: return 12'h060;
      5: return 12'h160;
      6: return 12'h1E0;
      7: return 12'h0E0;
      8: return 12'h180;
      default: return 12'($urandom_range(0, 'hFFF));
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R11 reset done", 32'(done), 0);
    check("R11 reset pc", npc, 0);
    check("R11 reset ssr", ssr, 0);
    rst_n = 1'b1;
    // R1: both pending, exception wins
    drive(1, 1, 12'h180, 1, 1, 12'h5A0, 32'h0000_00F0, 32'h1000, 32'h77, 32'h8000_0000, 0, 0);
    // R2: blocked exception -> reset request; R2 escape code 0x1E0
    drive(1, 1, 12'h0E0, 0, 0, 0, 32'h1000_0000, 32'h2000, 32'h88, 32'h8000_0000, 0, 0);
    drive(1, 1, 12'h1E0, 0, 0, 0, 32'h1000_0000, 32'h2000, 32'h88, 32'h8000_0000, 0, 0);
    // R3: blocked irq ignored awake, accepted asleep
    drive(1, 0, 0, 1, 1, 12'h320, 32'h1000_0030, 32'h3000, 32'h99, 32'h8C00_0000, 0, 0);
    drive(1, 0, 0, 1, 1, 12'h340, 32'h1000_0030, 32'h3000, 32'h99, 32'h8C00_0000, 0, 1);
    // R4: no vector -> ignored
    drive(1, 0, 0, 1, 0, 12'h360, 32'h0000_0020, 32'h4000, 32'h11, 32'h8C00_0000, 0, 0);
    // R6: irq in delay slot ignored; exception in delay slot rewinds
    drive(1, 0, 0, 1, 1, 12'h380, 32'h0, 32'h5000, 32'h22, 32'h8C00_0000, 1, 0);
    drive(1, 1, 12'h0A0, 0, 0, 0, 32'h0, 32'h5000, 32'h22, 32'h8C00_0000, 1, 0);
    // R7 reset-class, R8 tlb miss, R9 trap (plain and in delay slot)
    drive(1, 1, 12'h140, 0, 0, 0, 32'h0000_8010, 32'h6000, 32'h33, 32'h8C00_0000, 0, 0);
    drive(1, 1, 12'h060, 0, 0, 0, 32'h0, 32'h6100, 32'h33, 32'h8C00_0000, 0, 0);
    drive(1, 1, 12'h160, 0, 0, 0, 32'h0, 32'h6200, 32'h33, 32'h8C00_0000, 0, 0);
    drive(1, 1, 12'h160, 0, 0, 0, 32'h0, 32'h6300, 32'h33, 32'h8C00_0000, 1, 0);
    // R10 irq entry; R11 no strobe -> no change
    drive(1, 0, 0, 1, 1, 12'h3C0, 32'h0000_0050, 32'h7000, 32'h44, 32'h8C00_0000, 0, 0);
    drive(0, 1, 12'h020, 1, 1, 12'h3E0, 32'h1000_0000, 32'h7100, 32'h45, 32'h8D00_0000, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] s;
      s = $urandom;
      s[28] = ($urandom_range(0, 3) == 0);
      drive($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, pick_code(),
            $urandom_range(0, 1) == 1, $urandom_range(0, 3) != 0, 12'($urandom),
            s, $urandom, $urandom, $urandom, $urandom_range(0, 3) == 0,
            $urandom_range(0, 3) == 0);
    end
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (2) @(posedge clk);
    #5;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule